// File: doc/BRIEF.md
# Descriptor-Driven Memory Transfer Engine

This is a single-channel engine that copies data between two memory regions. It reads a 32-byte transfer descriptor from memory and runs it. The descriptor gives a source address, a destination address, a signed offset for each address, a beat-size code, a per-iteration byte count and an iteration count. Each outer (major) iteration moves the byte count as a series of beats. A beat is one read followed by one write of the coded size. After every beat, each address moves by its own offset.

Software gives the engine a descriptor address and a one-cycle kick. If the descriptor's start flag is set, the transfer runs as soon as the descriptor has been read. If the flag is clear, the engine holds the descriptor until a start pulse arrives. At completion the engine raises a done flag and can pulse an interrupt. If chaining is enabled, it treats one descriptor word as the address of the next descriptor, fetches that descriptor and runs it with no software involvement.

A descriptor that cannot run is rejected. The engine flags a configuration error and moves no data.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, mem_req_o, active_o, done_o, irq_o and cfg_err_o are all low.
- R2: A kick in idle makes the engine read eight 32-bit words (size code 2) from the kick address upward in steps of 4. In the bench's memory, byte i of mem_rdata_i holds the byte at the request address plus i. Word roles, as byte offsets from the descriptor base:
  - +0: source address.
  - +4: source offset in [15:0], source size code in [18:16], destination size code in [26:24].
  - +8: byte count.
  - +12: unused.
  - +16: destination address.
  - +20: destination offset in [15:0].
  - +24: next-descriptor address.
  - +28: iteration count in [8:0]; flags start [16], major interrupt enable [17], half interrupt enable [18], chain enable [20].
- R3: If the start flag is set, the transfer begins right after the fetch. If it is clear, nothing moves until start_i is pulsed.
- R4: Size codes 0, 1, 2, 4 and 5 mean 1, 2, 4, 16 and 32 bytes. Each beat reads the source at the coded size, and in the next cycle writes the returned bytes to the destination at the same size code. Writes occur only while active_o is high.
- R5: After each beat, the source address moves by its sign-extended 16-bit offset and the destination address moves by its own. Zero and negative offsets are allowed.
- R6: Each major iteration moves exactly the byte count. The current count is loaded from the iteration field when the transfer begins and drops by one per finished iteration. The total number of beats is the iteration count times the byte count divided by the beat size.
- R7: active_o is high from the launch to the last beat. In the cycle that active_o falls, done_o rises. done_o and active_o are never high together. done_o clears at the next kick or launch.
- R8: When the major interrupt enable is set, completion gives irq_o as a single-cycle pulse. When the enable is clear, completion gives no pulse.
- R9: When the half interrupt enable is set and the iteration count is 2 or more, irq_o pulses once when the current count drops to the iteration count shifted right by one.
- R10: The engine rejects a descriptor in any of these cases: a zero byte count, a byte count that is not a multiple of the beat size, a zero iteration count, an unknown size code, or source and destination size codes that differ. It then raises cfg_err_o, keeps active_o low and performs no write. cfg_err_o clears at the next kick.
- R11: When the chain enable is set, completion starts a fetch of the descriptor at the next-descriptor address. That descriptor runs if its own start flag is set.
- R12: A kick while the engine is not idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kick_i | input | 1 | Fetch the descriptor at desc_addr_i |
| desc_addr_i | input | 32 | Descriptor base address |
| start_i | input | 1 | Start a fetched descriptor whose start flag is clear |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | 32 | Access byte address |
| mem_size_o | output | 3 | Access size code |
| mem_wdata_o | output | 256 | Write data, byte i goes to address plus i |
| mem_rdata_i | input | 256 | Read data, valid the cycle after a read request |
| active_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Last transfer completed |
| irq_o | output | 1 | Interrupt pulse |
| cfg_err_o | output | 1 | Descriptor rejected |

## Verification
Three things happen together on the final write beat of a chained descriptor. done_o rises, irq_o pulses, and a read request for the next descriptor appears in the very next cycle. The bench builds two linked descriptors, both with the major interrupt enabled. It counts two done edges and two interrupt pulses, and it checks memory against a model that applies the two copies in order. Half-count and completion interrupts from the same descriptor are provoked together as well, and the two pulses must be counted separately.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 8;

  // descriptor word slots (the next-descriptor slot is fetched by chaining)
  localparam int W_SRC  = 0;
  localparam int W_CFG  = 1;
  localparam int W_NBY  = 2;
  localparam int W_DST  = 4;
  localparam int W_DOFF = 5;
  localparam int W_NEXT = 6;
  localparam int W_CTRL = 7;

  localparam int F_START = 16;
  localparam int F_IMAJ  = 17;
  localparam int F_IHALF = 18;
  localparam int F_CHAIN = 20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FREQ, ST_FCAP, ST_CHK, ST_WAIT, ST_LAUNCH, ST_RD, ST_WR
  } eng_state_e;

  function automatic logic [6:0] beat_bytes(input logic [2:0] code);
    case (code)
      3'd0:    beat_bytes = 7'd1;
      3'd1:    beat_bytes = 7'd2;
      3'd2:    beat_bytes = 7'd4;
      3'd4:    beat_bytes = 7'd16;
      3'd5:    beat_bytes = 7'd32;
      default: beat_bytes = 7'd0;
    endcase
  endfunction
endpackage

// File: rtl/dma_desc_store.sv
module dma_desc_store #(
  parameter int NW = 8,
  parameter int DW = 32,
  localparam int IW = $clog2(NW)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cap_i,
  input  logic [IW-1:0]          idx_i,
  input  logic [DW-1:0]          word_i,
  output logic [NW-1:0][DW-1:0]  words_o
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          words_o[g] <= '0;
      else if (cap_i && idx_i == IW'(g))    words_o[g] <= word_i;
    end
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [OW-1:0] soff_i,
  input  logic [OW-1:0] doff_i,
  input  logic          step_src_i,
  input  logic          step_dst_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o
);
  logic [AW-1:0] soff_ext, doff_ext;
  assign soff_ext = {{(AW-OW){soff_i[OW-1]}}, soff_i};
  assign doff_ext = {{(AW-OW){doff_i[OW-1]}}, doff_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o <= '0;
      dst_o <= '0;
    end else if (load_i) begin
      src_o <= src_i;
      dst_o <= dst_i;
    end else begin
      if (step_src_i) src_o <= src_o + soff_ext;
      if (step_dst_i) dst_o <= dst_o + doff_ext;
    end
  end
endmodule

// File: rtl/dma_loop_ctr.sv
module dma_loop_ctr #(
  parameter int BW = 32,
  parameter int CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [BW-1:0] nbytes_i,
  input  logic [CW-1:0] biter_i,
  input  logic [6:0]    beat_i,
  input  logic          step_i,
  output logic [CW-1:0] citer_o,
  output logic          minor_last_o
);
  logic [BW-1:0] rem_q;
  assign minor_last_o = (rem_q == BW'(beat_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      citer_o <= '0;
    end else if (load_i) begin
      rem_q   <= nbytes_i;
      citer_o <= biter_i;
    end else if (step_i) begin
      if (minor_last_o) begin
        rem_q   <= nbytes_i;
        citer_o <= citer_o - 1'b1;
      end else begin
        rem_q   <= rem_q - BW'(beat_i);
      end
    end
  end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_eng_pkg::*;
#(
  parameter int BUS_BYTES = 32,
  parameter int CNT_W     = 9,
  localparam int DATA_W   = 8 * BUS_BYTES,
  localparam int IDX_W    = $clog2(DESC_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kick_i,
  input  logic [31:0]       desc_addr_i,
  input  logic              start_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [2:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              active_o,
  output logic              done_o,
  output logic              irq_o,
  output logic              cfg_err_o
);
  eng_state_e st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  logic [31:0] fbase_q;
  logic done_q, irq_q, err_q;
  logic [DESC_WORDS-1:0][WORD_W-1:0] words;

  dma_desc_store #(.NW(DESC_WORDS), .DW(WORD_W)) u_store (
    .clk_i, .rst_ni,
    .cap_i  (st_q == ST_FCAP),
    .idx_i  (idx_q),
    .word_i (mem_rdata_i[WORD_W-1:0]),
    .words_o(words)
  );

  logic [2:0]  ssize, dsize;
  logic [15:0] soff, doff;
  logic [CNT_W-1:0] biter;
  logic [6:0]  beat;
  logic cfg_bad, f_start, f_imaj, f_ihalf, f_chain;

  assign soff    = words[W_CFG][15:0];
  assign ssize   = words[W_CFG][18:16];
  assign dsize   = words[W_CFG][26:24];
  assign doff    = words[W_DOFF][15:0];
  assign biter   = words[W_CTRL][CNT_W-1:0];
  assign f_start = words[W_CTRL][F_START];
  assign f_imaj  = words[W_CTRL][F_IMAJ];
  assign f_ihalf = words[W_CTRL][F_IHALF];
  assign f_chain = words[W_CTRL][F_CHAIN];
  assign beat    = beat_bytes(ssize);

  assign cfg_bad = (beat == '0) || (ssize != dsize) || (32'(beat) > BUS_BYTES) ||
                   (words[W_NBY] == '0) || ((words[W_NBY] & 32'(beat - 7'd1)) != '0) ||
                   (biter == '0);

  logic launch_ok, ctr_load;
  logic [31:0] src_a, dst_a;
  logic [CNT_W-1:0] citer;
  logic minor_last, major_last, fin, half_hit;

  assign launch_ok = (st_q == ST_LAUNCH) && !cfg_bad;
  assign ctr_load  = launch_ok;

  dma_addr_gen #(.AW(32), .OW(16)) u_addr (
    .clk_i, .rst_ni,
    .load_i    (ctr_load),
    .src_i     (words[W_SRC]),
    .dst_i     (words[W_DST]),
    .soff_i    (soff),
    .doff_i    (doff),
    .step_src_i(st_q == ST_RD),
    .step_dst_i(st_q == ST_WR),
    .src_o     (src_a),
    .dst_o     (dst_a)
  );

  dma_loop_ctr #(.BW(32), .CW(CNT_W)) u_loop (
    .clk_i, .rst_ni,
    .load_i      (ctr_load),
    .nbytes_i    (words[W_NBY]),
    .biter_i     (biter),
    .beat_i      (beat),
    .step_i      (st_q == ST_WR),
    .citer_o     (citer),
    .minor_last_o(minor_last)
  );

  assign major_last = minor_last && (citer == CNT_W'(1));
  assign fin        = (st_q == ST_WR) && major_last;
  assign half_hit   = (st_q == ST_WR) && minor_last && !major_last && f_ihalf &&
                      ((citer - 1'b1) == (biter >> 1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (kick_i) st_d = ST_FREQ;
      ST_FREQ:   st_d = ST_FCAP;
      ST_FCAP:   st_d = (idx_q == IDX_W'(DESC_WORDS - 1)) ? ST_CHK : ST_FREQ;
      ST_CHK:    st_d = f_start ? ST_LAUNCH : ST_WAIT;
      ST_WAIT:   if (start_i) st_d = ST_LAUNCH;
      ST_LAUNCH: st_d = cfg_bad ? ST_IDLE : ST_RD;
      ST_RD:     st_d = ST_WR;
      ST_WR:     if (major_last) st_d = f_chain ? ST_FREQ : ST_IDLE;
                 else            st_d = ST_RD;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      fbase_q <= '0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= (fin && f_imaj) || half_hit;
      if (st_q == ST_IDLE && kick_i) begin
        fbase_q <= desc_addr_i;
        idx_q   <= '0;
        done_q  <= 1'b0;
        err_q   <= 1'b0;
      end
      if (st_q == ST_FCAP) idx_q <= idx_q + 1'b1;
      if (st_q == ST_LAUNCH && cfg_bad) err_q <= 1'b1;
      if (launch_ok) done_q <= 1'b0;
      if (fin) begin
        done_q  <= 1'b1;
        idx_q   <= '0;
        fbase_q <= words[W_NEXT];
      end
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_size_o  = '0;
    mem_wdata_o = '0;
    unique case (st_q)
      ST_FREQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = fbase_q + {27'd0, idx_q, 2'b00};
        mem_size_o = 3'd2;
      end
      ST_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = src_a;
        mem_size_o = ssize;
      end
      ST_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dst_a;
        mem_size_o  = dsize;
        mem_wdata_o = mem_rdata_i;
      end
      default: ;
    endcase
  end

  assign active_o  = (st_q == ST_RD) || (st_q == ST_WR);
  assign done_o    = done_q;
  assign irq_o     = irq_q;
  assign cfg_err_o = err_q;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mem_req_o,
  input logic mem_we_o,
  input logic active_o,
  input logic done_o,
  input logic irq_o,
  input logic cfg_err_o
);
  // R7
  done_active_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(active_o && done_o));

  // R7
  fall_sets_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> done_o);

  // R8
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R4
  wr_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> $past(mem_req_o && !mem_we_o));

  // R4
  no_idle_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> active_o);

  // R10
  cfg_err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!active_o && !(mem_req_o && mem_we_o)));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk u_chk (
  .clk_i, .rst_ni, .mem_req_o, .mem_we_o, .active_o, .done_o, .irq_o, .cfg_err_o
);

// File: tb/dma_xfer_engine_test.sv
`timescale 1ns/1ps
module dma_xfer_engine_test;
  localparam int MSZ  = 4096;
  localparam int MASK = MSZ - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic kick_i = 1'b0, start_i = 1'b0;
  logic [31:0] desc_addr_i = '0;
  logic mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [2:0] mem_size_o;
  logic [255:0] mem_wdata_o, mem_rdata_i;
  logic active_o, done_o, irq_o, cfg_err_o;

  always #5 clk_i = ~clk_i;

  dma_xfer_engine uut (.*);

  logic [7:0] mem [MSZ];
  logic [7:0] ref_mem [MSZ];

  function automatic int bsz(input int code);
    case (code)
      0: return 1; 1: return 2; 2: return 4; 4: return 16; 5: return 32;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk_i) begin
    if (mem_req_o) begin
      if (mem_we_o) begin
        for (int b = 0; b < bsz(int'(mem_size_o)); b++)
          mem[(mem_addr_o + b) & MASK] <= mem_wdata_o[8*b +: 8];
      end else begin
        for (int b = 0; b < 32; b++)
          mem_rdata_i[8*b +: 8] <= mem[(mem_addr_o + b) & MASK];
      end
    end
  end

  int checks = 0, fails = 0;
  int wr_cnt = 0, irq_cnt = 0, done_rise = 0, size_bad = 0, fall_bad = 0;
  int exp_code = 0;
  bit done_prev = 0, act_prev = 0, fetch_armed = 0;
  logic [31:0] first_fetch = '0;

  always @(negedge clk_i) begin
    if (mem_req_o && mem_we_o) begin
      wr_cnt++;
      if (int'(mem_size_o) != exp_code) size_bad++;
    end
    if (irq_o) irq_cnt++;
    if (done_o && !done_prev) done_rise++;
    if (act_prev && !active_o && !done_o) fall_bad++;
    if (fetch_armed && mem_req_o) begin
      first_fetch = mem_addr_o;
      fetch_armed = 0;
    end
    done_prev = done_o;
    act_prev  = active_o;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic put_word(input int a, input logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      mem[(a + b) & MASK]     = w[8*b +: 8];
      ref_mem[(a + b) & MASK] = w[8*b +: 8];
    end
  endtask

  task automatic put_desc(input int base, input int src, input int dst,
                          input int soff, input int doff, input int sc, input int dc,
                          input int nby, input int biter, input bit st,
                          input bit imaj, input bit ihalf, input bit chain, input int nxt);
    logic [15:0] so, dof;
    so  = 16'(soff);
    dof = 16'(doff);
    put_word(base + 0,  32'(src));
    put_word(base + 4,  {5'd0, 3'(dc), 5'd0, 3'(sc), so});
    put_word(base + 8,  32'(nby));
    put_word(base + 12, 32'd0);
    put_word(base + 16, 32'(dst));
    put_word(base + 20, {16'd0, dof});
    put_word(base + 24, 32'(nxt));
    put_word(base + 28, {11'd0, chain, 1'b0, ihalf, imaj, st, 7'd0, 9'(biter)});
  endtask

  task automatic apply_ref(input int src, input int dst, input int soff, input int doff,
                           input int code, input int nby, input int biter);
    logic [7:0] tmp [32];
    int s = src, d = dst, n = bsz(code);
    for (int i = 0; i < biter; i++)
      for (int j = 0; j < nby / n; j++) begin
        for (int b = 0; b < n; b++) tmp[b] = ref_mem[(s + b) & MASK];
        for (int b = 0; b < n; b++) ref_mem[(d + b) & MASK] = tmp[b];
        s += soff;
        d += doff;
      end
  endtask

  function automatic int mem_diff();
    int n = 0;
    for (int i = 0; i < MSZ; i++) if (mem[i] !== ref_mem[i]) n++;
    return n;
  endfunction

  task automatic kick(input int base);
    @(negedge clk_i);
    kick_i = 1'b1;
    desc_addr_i = 32'(base);
    fetch_armed = 1;
    @(negedge clk_i);
    kick_i = 1'b0;
  endtask

  task automatic wait_fin(input int target);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_i);
      if (done_rise >= target || cfg_err_o) break;
    end
    repeat (3) @(negedge clk_i);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int w0, i0, d0, code, n, nby, biter, src, dst, soff, doff, imaj;
    void'($urandom(32'd5150));
    for (int i = 0; i < MSZ; i++) begin
      mem[i] = 8'($urandom);
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk_i);
    chk(!mem_req_o && !active_o && !done_o && !irq_o && !cfg_err_o, "R1", "reset outputs",
        {mem_req_o, active_o, done_o, irq_o, cfg_err_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!mem_req_o && !done_o, "R1", "idle after reset", mem_req_o, 0);

    // random transfers: R4 R5 R6 R8
    for (int t = 0; t < 12; t++) begin
      case ($urandom % 5) 0: code = 0; 1: code = 1; 2: code = 2; 3: code = 4; default: code = 5; endcase
      n = bsz(code);
      nby = n * (1 + $urandom % 3);
      biter = 1 + $urandom % 3;
      case ($urandom % 4) 0: soff = n; 1: soff = -n; 2: soff = 2 * n; default: soff = 0; endcase
      case ($urandom % 4) 0: doff = n; 1: doff = -n; 2: doff = 2 * n; default: doff = 0; endcase
      src = 32'h300 + $urandom % 32'h1E0;
      dst = 32'h300 + $urandom % 32'h1E0;
      imaj = $urandom % 2;
      exp_code = code;
      w0 = wr_cnt; i0 = irq_cnt; d0 = done_rise;
      put_desc(32'h800, src, dst, soff, doff, code, code, nby, biter, 1, imaj[0], 0, 0, 0);
      apply_ref(src, dst, soff, doff, code, nby, biter);
      kick(32'h800);
      wait_fin(d0 + 1);
      chk(mem_diff() == 0, "R5", "memory image after random copy", mem_diff(), 0);
      chk(wr_cnt - w0 == biter * nby / n, "R6", "write beats", wr_cnt - w0, biter * nby / n);
      chk(irq_cnt - i0 == imaj, "R8", "irq pulses", irq_cnt - i0, imaj);
      chk(done_o && !active_o, "R7", "done after transfer", done_o, 1);
    end
    chk(size_bad == 0, "R4", "write size code", size_bad, 0);
    chk(first_fetch == 32'h800, "R2", "first fetch address", first_fetch, 32'h800);

    // half and major interrupts in one descriptor: R9
    exp_code = 2; i0 = irq_cnt; d0 = done_rise;
    put_desc(32'h800, 32'h300, 32'h500, 4, 4, 2, 2, 8, 4, 1, 1, 1, 0, 0);
    apply_ref(32'h300, 32'h500, 4, 4, 2, 8, 4);
    kick(32'h800);
    wait_fin(d0 + 1);
    chk(irq_cnt - i0 == 2, "R9", "half plus major irqs", irq_cnt - i0, 2);
    i0 = irq_cnt; d0 = done_rise;
    put_desc(32'h800, 32'h300, 32'h500, 4, 4, 2, 2, 8, 1, 1, 0, 1, 0, 0);
    apply_ref(32'h300, 32'h500, 4, 4, 2, 8, 1);
    kick(32'h800);
    wait_fin(d0 + 1);
    chk(irq_cnt - i0 == 0, "R9", "no half irq with count 1", irq_cnt - i0, 0);

    // start flag clear waits for start_i: R3
    exp_code = 1; w0 = wr_cnt; d0 = done_rise;
    put_desc(32'h800, 32'h320, 32'h420, -2, 2, 1, 1, 6, 2, 0, 0, 0, 0, 0);
    apply_ref(32'h320, 32'h420, -2, 2, 1, 6, 2);
    kick(32'h800);
    repeat (60) @(negedge clk_i);
    chk(wr_cnt == w0 && !active_o && !done_o, "R3", "no writes before start_i", wr_cnt - w0, 0);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_fin(d0 + 1);
    chk(mem_diff() == 0, "R3", "copy after start_i", mem_diff(), 0);

    // rejected descriptors: R10
    w0 = wr_cnt;
    put_desc(32'h800, 32'h300, 32'h400, 4, 4, 2, 2, 6, 1, 1, 0, 0, 0, 0);
    kick(32'h800);
    wait_fin(done_rise + 1);
    chk(cfg_err_o && !done_o && wr_cnt == w0, "R10", "byte count not multiple", wr_cnt - w0, 0);
    put_desc(32'h800, 32'h300, 32'h400, 4, 4, 2, 2, 8, 0, 1, 0, 0, 0, 0);
    kick(32'h800);
    wait_fin(done_rise + 1);
    chk(cfg_err_o && wr_cnt == w0, "R10", "zero iteration count", wr_cnt - w0, 0);
    put_desc(32'h800, 32'h300, 32'h400, 4, 4, 2, 1, 8, 1, 1, 0, 0, 0, 0);
    kick(32'h800);
    wait_fin(done_rise + 1);
    chk(cfg_err_o && wr_cnt == w0, "R10", "size codes differ", wr_cnt - w0, 0);
    chk(mem_diff() == 0, "R10", "memory untouched", mem_diff(), 0);

    // kick while busy is ignored: R12
    exp_code = 0; d0 = done_rise;
    put_desc(32'h800, 32'h300, 32'h400, 1, 1, 0, 0, 64, 3, 1, 0, 0, 0, 0);
    put_desc(32'h900, 32'h600, 32'h500, 1, 1, 0, 0, 64, 1, 1, 0, 0, 0, 0);
    apply_ref(32'h300, 32'h400, 1, 1, 0, 64, 3);
    kick(32'h800);
    chk(!cfg_err_o, "R10", "error cleared by kick", cfg_err_o, 0);
    repeat (40) @(negedge clk_i);
    kick(32'h900);
    wait_fin(d0 + 1);
    repeat (40) @(negedge clk_i);
    chk(mem_diff() == 0, "R12", "second kick ignored", mem_diff(), 0);

    // chained descriptors, completion and next fetch together: R11
    exp_code = 4; i0 = irq_cnt; d0 = done_rise;
    put_desc(32'h800, 32'h300, 32'h480, 16, -16, 4, 4, 32, 2, 1, 1, 0, 1, 32'h840);
    put_desc(32'h840, 32'h480, 32'h600, 16, 16, 4, 4, 16, 2, 1, 1, 0, 0, 0);
    apply_ref(32'h300, 32'h480, 16, -16, 4, 32, 2);
    apply_ref(32'h480, 32'h600, 16, 16, 4, 16, 2);
    kick(32'h800);
    wait_fin(d0 + 2);
    chk(done_rise - d0 == 2, "R11", "two completions", done_rise - d0, 2);
    chk(irq_cnt - i0 == 2, "R11", "two irq pulses", irq_cnt - i0, 2);
    chk(mem_diff() == 0, "R11", "chained memory image", mem_diff(), 0);
    chk(fall_bad == 0, "R7", "done rises as active falls", fall_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule